// File: doc/BRIEF.md
# Masked Vector Lane Extraction Unit

This unit copies one aligned slice out of a wide source vector and places it in the low part of a destination vector. The slice is either 128 or 256 bits wide. It is taken from a 256-bit or 512-bit source, at an offset that the low bits of an 8-bit immediate select. The slice is then written element by element under a write mask. An element is 32 or 64 bits. For a register destination, each element whose mask bit is clear either keeps its old value (merging) or becomes zero (zeroing). All bits above the slice are cleared.

For a memory destination only merging applies. The unit then also drives a per-byte write-strobe vector, so that a store port writes only the elements that are enabled. Bits above the slice keep the old value and get no strobe. An encoding check raises an invalid-opcode flag. While the flag is set, the destination is passed through unchanged and no strobe is driven. The datapath is combinational. An optional register stage, on by default, adds one cycle of latency and carries a valid bit.

Top module: `vlane_extract_unit`

## Requirements
- R1: With a 128-bit slice and a 256-bit source (`src_is_512`=0), immediate bit 0 alone selects source bits 127:0 (0) or 255:128 (1). Immediate bits 7:1 have no effect.
- R2: With a 128-bit slice and a 512-bit source, immediate bits 1:0 select the slice at bit offset 128 times their value. Immediate bits 7:2 have no effect.
- R3: With a 256-bit slice (`slice_is_256`=1), immediate bit 0 selects source bits 255:0 or 511:256. `src_is_512` and immediate bits 7:1 have no effect.
- R4: With `elem_is_64`=0, the mask applies per 32-bit element. With `elem_is_64`=1, mask bit j governs the 64-bit element j. Only the low 4/2 bits (128-bit slice) or 8/4 bits (256-bit slice) of the mask are used. When `mask_on`=0 or `legacy_form`=1, every element of the slice is written.
- R5: For a register destination (`to_memory`=0), an element whose mask bit is clear becomes zero when `zeroing`=1 and keeps its `old_dst` value when `zeroing`=0.
- R6: For a register destination, every bit of `dst_out` above the slice width is zero and `byte_we` is all zero.
- R7: For a memory destination, an element whose mask bit is clear keeps its old value whatever `zeroing` is, and bits above the slice keep `old_dst`. `byte_we` bit b is 1 exactly when byte b lies inside the slice and its element is enabled.
- R8: `inv_op` is 1 when `xreg_spec` is not 4'b1111, or when `legacy_form`=1 with `len_bit`=0. While `inv_op` is 1, `dst_out` equals `old_dst` and `byte_we` is zero.
- R9: With the register stage enabled (PIPE=1), `out_valid`, `dst_out`, `byte_we` and `inv_op` appear one clock after the inputs are presented. `out_valid` follows `in_valid` with one cycle of delay. Reset clears all four outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation presented this cycle |
| src_vec | input | 512 | Source vector |
| old_dst | input | 512 | Current destination contents |
| imm | input | 8 | Slice-select immediate |
| mask | input | 8 | Element write mask |
| mask_on | input | 1 | 1 = mask applies, 0 = all elements written |
| src_is_512 | input | 1 | Source length is 512 bits (else 256) |
| slice_is_256 | input | 1 | Slice is 256 bits (else 128) |
| elem_is_64 | input | 1 | Element size is 64 bits (else 32) |
| zeroing | input | 1 | Zero masked-off elements (register destination only) |
| to_memory | input | 1 | Destination is memory |
| legacy_form | input | 1 | Unmasked legacy 128-bit form |
| len_bit | input | 1 | Vector-length bit of the legacy encoding |
| xreg_spec | input | 4 | Extra-register specifier field, must be 1111b |
| out_valid | output | 1 | Result valid |
| dst_out | output | 512 | New destination value |
| byte_we | output | 64 | Per-byte write strobes for a memory store |
| inv_op | output | 1 | Invalid-opcode fault |

## Verification
Two things can happen in the same cycle that pull `dst_out` and `byte_we` in opposite directions. The fault check forces them back to the old value and to silence, while masking with a memory destination tries to merge the slice and raise strobes. The bench sends illegal specifiers and legacy forms with the length bit clear, each with a full mask and a memory destination. It expects the old destination and zero strobes even though every element is enabled. Merging and upper-bit handling also act together on the same cycle. A sweep over all masks, immediates, slice and element sizes, zeroing settings and targets compares every bit against an arithmetic model: merged or zeroed lanes inside the slice, cleared or kept bits above it.

// File: rtl/vx_pkg.sv
// Shared constants and configuration struct for the lane extraction unit.
package vx_pkg;
    localparam int unsigned LANE_W  = 32;   // finest element granularity
    localparam int unsigned CHUNK_W = 128;  // slice-offset granularity

    // Decoded per-operation configuration.
    typedef struct packed {
        logic src512;
        logic slice256;
        logic elem64;
        logic zeroing;
        logic to_mem;
        logic masked;
    } vx_cfg_t;
endpackage

// File: rtl/vx_slice_sel.sv
// Picks a 128- or 256-bit aligned slice out of the source vector.
// Assumes: base is in 128-bit chunk units and is already aligned for the
// slice width (even for 256-bit slices). Unused upper slice bits are zero.
module vx_slice_sel #(
    parameter int unsigned VEC_W   = 512,
    parameter int unsigned CHUNK_W = 128
) (
    input  logic [VEC_W-1:0]       src,
    input  logic [1:0]             base,
    input  logic                   wide,
    output logic [VEC_W/2-1:0]     slice
);
    localparam int unsigned NCHUNK  = VEC_W / CHUNK_W;
    localparam int unsigned NOUT    = (VEC_W / 2) / CHUNK_W;

    logic [CHUNK_W-1:0] chunk [NCHUNK];

    // Split the source into fixed chunks.
    for (genvar c = 0; c < NCHUNK; c++) begin : g_chunk
        assign chunk[c] = src[c*CHUNK_W +: CHUNK_W];
    end

    // Route chunk base+k to output chunk k; the second chunk only for wide slices.
    always_comb begin
        slice = '0;
        for (int k = 0; k < NOUT; k++) begin
            if (k == 0 || wide) begin
                slice[k*CHUNK_W +: CHUNK_W] = chunk[(int'(base) + k) % NCHUNK];
            end
        end
    end
endmodule

// File: rtl/vx_lane_en.sv
// Expands the element mask into per-32-bit-lane "in slice" and "enabled" flags.
// Assumes: a 64-bit element covers two adjacent 32-bit lanes and uses one mask bit.
module vx_lane_en #(
    parameter int unsigned NLANE  = 16,
    parameter int unsigned MASK_W = 8
) (
    input  logic [MASK_W-1:0] mask,
    input  logic              masked,
    input  logic              elem64,
    input  logic              slice256,
    output logic [NLANE-1:0]  lane_in,
    output logic [NLANE-1:0]  lane_en
);
    localparam int unsigned LANES_NARROW = 4;
    localparam int unsigned LANES_WIDE   = 8;

    for (genvar l = 0; l < NLANE; l++) begin : g_lane
        logic bit32;
        logic bit64;
        // Mask bit seen by this lane for 32-bit elements.
        if (l < MASK_W) begin : g_m32
            assign bit32 = mask[l];
        end else begin : g_m32_none
            assign bit32 = 1'b0;
        end
        // Mask bit seen by this lane for 64-bit elements.
        if ((l / 2) < MASK_W) begin : g_m64
            assign bit64 = mask[l/2];
        end else begin : g_m64_none
            assign bit64 = 1'b0;
        end
        // Lane is inside the slice when below the slice's lane count.
        assign lane_in[l] = slice256 ? (l < LANES_WIDE) : (l < LANES_NARROW);
        // Lane is written when inside the slice and unmasked or its mask bit set.
        assign lane_en[l] = lane_in[l] & (~masked | (elem64 ? bit64 : bit32));
    end
endmodule

// File: rtl/vx_merge.sv
// Builds the new destination and per-byte strobes from slice, old value and lane flags.
// Assumes: lane flags come from vx_lane_en; a fault overrides everything.
module vx_merge #(
    parameter int unsigned VEC_W  = 512,
    parameter int unsigned LANE_W = 32
) (
    input  logic [VEC_W/2-1:0]        slice,
    input  logic [VEC_W-1:0]          old,
    input  logic [VEC_W/LANE_W-1:0]   lane_in,
    input  logic [VEC_W/LANE_W-1:0]   lane_en,
    input  logic                      zeroing,
    input  logic                      to_mem,
    input  logic                      fault,
    output logic [VEC_W-1:0]          dst,
    output logic [VEC_W/8-1:0]        bwe
);
    localparam int unsigned NLANE   = VEC_W / LANE_W;
    localparam int unsigned SLANES  = (VEC_W / 2) / LANE_W;
    localparam int unsigned LBYTES  = LANE_W / 8;

    for (genvar l = 0; l < NLANE; l++) begin : g_lane
        logic [LANE_W-1:0] new_v;
        logic [LANE_W-1:0] old_v;
        // Slice data for this lane, none beyond the widest slice.
        if (l < SLANES) begin : g_has
            assign new_v = slice[l*LANE_W +: LANE_W];
        end else begin : g_none
            assign new_v = '0;
        end
        assign old_v = old[l*LANE_W +: LANE_W];

        // Lane value: fault keeps old; enabled takes slice; else merge, zero or clear.
        always_comb begin
            if (fault)              dst[l*LANE_W +: LANE_W] = old_v;
            else if (lane_en[l])    dst[l*LANE_W +: LANE_W] = new_v;
            else if (to_mem)        dst[l*LANE_W +: LANE_W] = old_v;
            else if (lane_in[l] && !zeroing) dst[l*LANE_W +: LANE_W] = old_v;
            else                    dst[l*LANE_W +: LANE_W] = '0;
        end

        // Byte strobes only for enabled lanes going to memory.
        assign bwe[l*LBYTES +: LBYTES] = {LBYTES{to_mem & lane_en[l] & ~fault}};
    end
endmodule

// File: rtl/vlane_extract_unit.sv
// Masked vector lane extraction unit: selects an immediate-indexed slice,
// applies the element mask, checks encoding legality and optionally registers.
// Assumes: PIPE=1 gives one cycle latency; PIPE=0 is purely combinational.
module vlane_extract_unit #(
    parameter int unsigned VEC_W  = 512,
    parameter int unsigned MASK_W = 8,
    parameter int unsigned IMM_W  = 8,
    parameter int unsigned SPEC_W = 4,
    parameter bit          PIPE   = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [VEC_W-1:0]     src_vec,
    input  logic [VEC_W-1:0]     old_dst,
    input  logic [IMM_W-1:0]     imm,
    input  logic [MASK_W-1:0]    mask,
    input  logic                 mask_on,
    input  logic                 src_is_512,
    input  logic                 slice_is_256,
    input  logic                 elem_is_64,
    input  logic                 zeroing,
    input  logic                 to_memory,
    input  logic                 legacy_form,
    input  logic                 len_bit,
    input  logic [SPEC_W-1:0]    xreg_spec,
    output logic                 out_valid,
    output logic [VEC_W-1:0]     dst_out,
    output logic [VEC_W/8-1:0]   byte_we,
    output logic                 inv_op
);
    import vx_pkg::*;

    localparam int unsigned NLANE  = VEC_W / LANE_W;
    localparam int unsigned NBYTE  = VEC_W / 8;
    localparam int unsigned SLICEW = VEC_W / 2;

    vx_cfg_t             cfg;
    logic [1:0]          base;
    logic                fault;
    logic [SLICEW-1:0]   slice;
    logic [NLANE-1:0]    lane_in;
    logic [NLANE-1:0]    lane_en;
    logic [VEC_W-1:0]    c_dst;
    logic [NBYTE-1:0]    c_we;
    logic                unused_imm_hi;

    // Gather the configuration; the legacy form never uses the mask.
    always_comb begin
        cfg.src512   = src_is_512;
        cfg.slice256 = slice_is_256;
        cfg.elem64   = elem_is_64;
        cfg.zeroing  = zeroing;
        cfg.to_mem   = to_memory;
        cfg.masked   = mask_on & ~legacy_form;
    end

    // Slice base in 128-bit units from the low immediate bits.
    always_comb begin
        if (cfg.slice256)    base = {imm[0], 1'b0};
        else if (cfg.src512) base = imm[1:0];
        else                 base = {1'b0, imm[0]};
    end
    assign unused_imm_hi = ^imm[IMM_W-1:2];

    // Encoding legality: specifier must be all ones, legacy form needs length bit.
    assign fault = (xreg_spec != {SPEC_W{1'b1}}) | (legacy_form & ~len_bit);

    vx_slice_sel #(.VEC_W(VEC_W), .CHUNK_W(CHUNK_W)) u_sel (
        .src   (src_vec),
        .base  (base),
        .wide  (cfg.slice256),
        .slice (slice)
    );

    vx_lane_en #(.NLANE(NLANE), .MASK_W(MASK_W)) u_len (
        .mask     (mask),
        .masked   (cfg.masked),
        .elem64   (cfg.elem64),
        .slice256 (cfg.slice256),
        .lane_in  (lane_in),
        .lane_en  (lane_en)
    );

    vx_merge #(.VEC_W(VEC_W), .LANE_W(LANE_W)) u_mrg (
        .slice   (slice),
        .old     (old_dst),
        .lane_in (lane_in),
        .lane_en (lane_en),
        .zeroing (cfg.zeroing),
        .to_mem  (cfg.to_mem),
        .fault   (fault),
        .dst     (c_dst),
        .bwe     (c_we)
    );

    if (PIPE) begin : g_pipe
        // Output register stage, cleared by synchronous reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                out_valid <= 1'b0;
                dst_out   <= '0;
                byte_we   <= '0;
                inv_op    <= 1'b0;
            end else begin
                out_valid <= in_valid;
                dst_out   <= c_dst;
                byte_we   <= c_we;
                inv_op    <= fault;
            end
        end

        // R9: valid appears exactly one cycle after it is presented.
        a_r9_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);
        a_r9_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid);
        // R8: a registered fault carries the registered old destination.
        a_r8_fault_holds_old: assert property (@(posedge clk) disable iff (!rst_n)
            fault |=> (inv_op && dst_out == $past(old_dst)));
    end else begin : g_comb
        // Pass-through when no register stage is wanted.
        assign out_valid = in_valid;
        assign dst_out   = c_dst;
        assign byte_we   = c_we;
        assign inv_op    = fault;
    end

    // R8: no store strobe ever leaves alongside a fault.
    a_r8_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        inv_op |-> (byte_we == '0));
    // R6: register targets never raise strobes.
    a_r6_reg_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault && !to_memory) |-> (c_we == '0));
    // R6: narrow register result is cleared above 128 bits.
    a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault && !to_memory && !slice_is_256) |-> (c_dst[VEC_W-1:CHUNK_W] == '0));
    // R7: memory targets leave everything above the widest slice untouched.
    a_r7_mem_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault && to_memory) |-> (c_dst[VEC_W-1:SLICEW] == old_dst[VEC_W-1:SLICEW]));
    // R7: strobe count never exceeds the widest slice's bytes.
    a_r7_strobe_bound: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(c_we) <= (SLICEW / 8));
endmodule

// File: tb/sim_vlane_extract_unit.sv
module sim_vlane_extract_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [511:0] src_vec = '0;
    logic [511:0] old_dst = '0;
    logic [7:0]   imm = '0;
    logic [7:0]   mask = '0;
    logic         mask_on = 1'b0;
    logic         src_is_512 = 1'b0;
    logic         slice_is_256 = 1'b0;
    logic         elem_is_64 = 1'b0;
    logic         zeroing = 1'b0;
    logic         to_memory = 1'b0;
    logic         legacy_form = 1'b0;
    logic         len_bit = 1'b0;
    logic [3:0]   xreg_spec = 4'hF;
    logic         out_valid;
    logic [511:0] dst_out;
    logic [63:0]  byte_we;
    logic         inv_op;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    vlane_extract_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_vec(src_vec),
        .old_dst(old_dst), .imm(imm), .mask(mask), .mask_on(mask_on),
        .src_is_512(src_is_512), .slice_is_256(slice_is_256), .elem_is_64(elem_is_64),
        .zeroing(zeroing), .to_memory(to_memory), .legacy_form(legacy_form),
        .len_bit(len_bit), .xreg_spec(xreg_spec), .out_valid(out_valid),
        .dst_out(dst_out), .byte_we(byte_we), .inv_op(inv_op)
    );

    task automatic check(input string tag, input logic [511:0] got, input logic [511:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // Arithmetic model of the requirements.
    task automatic model(output logic [511:0] edst, output logic [63:0] ewe, output logic efault);
        int width, off, esz, nel;
        logic [511:0] tmp;
        logic on;
        efault = (xreg_spec != 4'hF) || (legacy_form && !len_bit);
        ewe = '0;
        if (efault) begin
            edst = old_dst;
            return;
        end
        width = slice_is_256 ? 256 : 128;
        if (slice_is_256)    off = imm[0] * 256;
        else if (src_is_512) off = imm[1:0] * 128;
        else                 off = imm[0] * 128;
        tmp = src_vec >> off;
        esz = elem_is_64 ? 64 : 32;
        nel = width / esz;
        edst = to_memory ? old_dst : '0;
        for (int e = 0; e < nel; e++) begin
            on = !mask_on || legacy_form || mask[e];
            for (int b = 0; b < esz; b++) begin
                int p;
                p = e * esz + b;
                if (on) edst[p] = tmp[p];
                else    edst[p] = (to_memory || !zeroing) ? old_dst[p] : 1'b0;
                if (on && to_memory) ewe[p/8] = 1'b1;
            end
        end
    endtask

    // One vector: inputs set now (negedge), result sampled at next negedge.
    task automatic run(input string dtag, input string wtag);
        logic [511:0] ed;
        logic [63:0]  ew;
        logic         ef;
        in_valid = 1'b1;
        model(ed, ew, ef);
        @(negedge clk);
        check(dtag, dst_out, ed);
        check(wtag, {448'd0, byte_we}, {448'd0, ew});
        check({dtag, "/R8 flag"}, {511'd0, inv_op}, {511'd0, ef});
    endtask

    task automatic randomize_data();
        for (int w = 0; w < 16; w++) begin
            src_vec[w*32 +: 32] = $urandom;
            old_dst[w*32 +: 32] = $urandom;
        end
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R9: reset state.
        check("R9 reset valid", {511'd0, out_valid}, 512'd0);
        check("R9 reset dst", dst_out, 512'd0);
        check("R9 reset we", {448'd0, byte_we}, 512'd0);
        check("R9 reset inv", {511'd0, inv_op}, 512'd0);
        rst_n = 1'b1;

        // R9: valid latency, rise then fall.
        in_valid = 1'b1;
        @(negedge clk);
        check("R9 valid rise", {511'd0, out_valid}, 512'd1);
        in_valid = 1'b0;
        @(negedge clk);
        check("R9 valid fall", {511'd0, out_valid}, 512'd0);

        // R1: upper immediate bits ignored, 256-bit source.
        randomize_data();
        mask_on = 1'b0; imm = 8'hFE;
        run("R1 imm FE", "R6 we");
        imm = 8'h03;
        run("R1 imm 03", "R6 we");

        // R4: masking disabled writes all; quadword uses only low 2 mask bits.
        mask_on = 1'b1; elem_is_64 = 1'b1; mask = 8'hFE; src_is_512 = 1'b1; imm = 8'h02;
        run("R4 q mask FE", "R6 we");
        legacy_form = 1'b1; len_bit = 1'b1; mask = 8'h00;
        run("R4 legacy unmasked", "R6 we");
        legacy_form = 1'b0;

        // R5: zeroing vs merging on a register.
        elem_is_64 = 1'b0; mask = 8'h05; zeroing = 1'b1;
        run("R5 zeroing", "R6 we");
        zeroing = 1'b0;
        run("R5 merging", "R6 we");

        // R8: faults coinciding with a memory store and full mask.
        to_memory = 1'b1; mask = 8'hFF; xreg_spec = 4'hE;
        run("R8 spec E", "R8 we");
        xreg_spec = 4'h7;
        run("R8 spec 7", "R8 we");
        xreg_spec = 4'hF; legacy_form = 1'b1; len_bit = 1'b0;
        run("R8 legacy len0", "R8 we");
        len_bit = 1'b1;
        run("R8 legacy len1 ok", "R7 we");
        legacy_form = 1'b0; to_memory = 1'b0;

        // Sweep all configurations, immediates and masks.
        mask_on = 1'b1;
        for (int cf = 0; cf < 32; cf++) begin
            src_is_512   = cf[0];
            slice_is_256 = cf[1];
            elem_is_64   = cf[2];
            zeroing      = cf[3];
            to_memory    = cf[4];
            for (int im = 0; im < 4; im++) begin
                for (int m = 0; m < 256; m++) begin
                    string dt;
                    randomize_data();
                    imm  = {6'($urandom), 2'(im)};
                    mask = 8'(m);
                    if (slice_is_256)    dt = "R3 slice256";
                    else if (src_is_512) dt = "R2 slice128/512";
                    else                 dt = "R1 slice128/256";
                    if (to_memory) dt = {dt, " R7 mem"};
                    else           dt = {dt, " R5 reg"};
                    run(dt, to_memory ? "R7 strobes" : "R6 strobes");
                end
            end
        end

        in_valid = 1'b0;
        @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule